// File: doc/BRIEF.md
# Supervisory Reset Pulse Sequencer

This block turns three independent reset causes into one clean processor reset. The causes are a supply-good level from an external voltage comparator, an active-low manual push-button input, and a single-cycle (or longer) timeout strobe from a watchdog timer. Any cause raises the reset at once. Once every cause has gone away, the reset stays raised for a fixed hold period, then drops. The result is driven on two complementary pins, one active high and one active low.

The supply-good and manual inputs are asynchronous, so each one passes through a two-flop synchronizer. The manual input is also debounced, so contact bounce and short spikes never reach the processor. All timing is counted in clock cycles. Two parameters set the hold period and the debounce window. A typical hold period is about 210 ms, and anything from 140 ms to 280 ms is acceptable: at a 1 MHz clock, for example, that is `HOLD_CYCLES` = 210000. After the block's own synchronous reset, the outputs start asserted and run one full hold period before they release.

Top module: `rst_pulse_seq`

## Requirements
- R1: When `supply_ok_i` goes low, reset asserts 3 clock cycles after the input change (two synchronizer flops plus the output register), with no hold-period delay.
- R2: When `supply_ok_i` returns high while no other cause is active, reset releases exactly `HOLD_CYCLES` + 2 cycles after the input change.
- R3: A low level on `man_rst_n_i` held for at least `DEB_CYCLES` cycles asserts reset `DEB_CYCLES` + 3 cycles after it falls. Reset stays asserted for as long as the input stays low.
- R4: After `man_rst_n_i` returns high, reset releases exactly `DEB_CYCLES` + 2 + `HOLD_CYCLES` cycles after the rising input change.
- R5: A low pulse on `man_rst_n_i` shorter than `DEB_CYCLES` cycles has no effect: `rst_o` stays 0.
- R6: A `wdog_bite_i` pulse raises reset on the next clock edge. Reset releases `HOLD_CYCLES` cycles after the last edge at which the pulse was sampled high.
- R7: A cause that appears while the hold count is running restarts the count. Release then comes `HOLD_CYCLES` cycles after the last cycle in which any cause was active.
- R8: `rst_n_o` is always the complement of `rst_o`. `rst_o` = 1 means reset is asserted.
- R9: During `srst`, `rst_o` = 1. After `srst` falls, with `supply_ok_i` = 1 and `man_rst_n_i` = 1, reset releases `HOLD_CYCLES` + 2 cycles after the first edge that samples `srst` low, minus one. In other words, it releases at edge r+2+`HOLD_CYCLES`, where edge r is the last edge that sampled `srst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| srst | input | 1 | Synchronous reset of the block, active high |
| supply_ok_i | input | 1 | Supply-good level from the comparator, asynchronous, high = good |
| man_rst_n_i | input | 1 | Manual reset request, asynchronous, active low |
| wdog_bite_i | input | 1 | Watchdog timeout strobe, synchronous, active high |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |

## Verification
The assertions check several rules on every cycle. Any active cause, including a watchdog strobe, must leave reset raised on the next edge. The hold timer may not release before its count reaches its last value. The debounced manual level may change only toward a value the synchronized input actually held. The bench's scenarios are needed for the rest, because those properties cannot see absolute cycle positions. Those scenarios are the exact assert and release cycles through the synchronizer and debounce pipeline, the rejection of a short manual glitch, the restart of the hold count when causes overlap, and the release timing after the block's own reset.

// File: rtl/rps_pkg.sv
package rps_pkg;

  // Width of a counter that must hold the values 0 .. n-1.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Release point of a hold window: the last count value before release.
  function automatic int unsigned last_count(input int unsigned n);
    return (n < 1) ? 0 : n - 1;
  endfunction

  typedef enum logic {
    HOLD_OFF = 1'b0,
    HOLD_ON  = 1'b1
  } hold_state_e;

endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic srst,
  input  logic d_i,
  output logic q_o
);

  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (srst) chain_q <= {N{RST_VAL}};
    else      chain_q <= {chain_q[N-2:0], d_i};
  end

  assign q_o = chain_q[N-1];

endmodule

// File: rtl/rps_debounce.sv
module rps_debounce #(
  parameter int unsigned DEB_CYCLES = 8,
  parameter bit          RST_VAL    = 1'b1
) (
  input  logic clk,
  input  logic srst,
  input  logic in_i,
  output logic out_o
);

  import rps_pkg::*;

  localparam int unsigned CW = cnt_bits(DEB_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(last_count(DEB_CYCLES));

  logic out_q;

  generate
    if (DEB_CYCLES < 2) begin : g_pass
      always_ff @(posedge clk) begin
        if (srst) out_q <= RST_VAL;
        else      out_q <= in_i;
      end
    end else begin : g_filter
      logic [CW-1:0] cnt_q;
      logic          differs;
      logic          flip;

      assign differs = (in_i != out_q);
      assign flip    = differs && (cnt_q == CNT_LAST);

      always_ff @(posedge clk) begin
        if (srst) begin
          out_q <= RST_VAL;
          cnt_q <= '0;
        end else if (!differs) begin
          cnt_q <= '0;
        end else if (flip) begin
          out_q <= in_i;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate

  assign out_o = out_q;

  // R5: the filtered level only ever moves to a value the input held.
  a_r5_follow_input: assert property (@(posedge clk) disable iff (srst)
    !$stable(out_q) |-> ($past(in_i) == out_q));

endmodule

// File: rtl/rps_hold_timer.sv
module rps_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 40
) (
  input  logic clk,
  input  logic srst,
  input  logic cause_i,
  output logic held_o
);

  import rps_pkg::*;

  localparam int unsigned CW = cnt_bits(HOLD_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(last_count(HOLD_CYCLES));

  hold_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          count_done;

  assign count_done = (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (srst) begin
      state_q <= HOLD_ON;
      cnt_q   <= '0;
    end else if (cause_i) begin
      state_q <= HOLD_ON;
      cnt_q   <= '0;
    end else if (state_q == HOLD_ON) begin
      if (count_done) begin
        state_q <= HOLD_OFF;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign held_o = (state_q == HOLD_ON);

  // R1: any active cause leaves reset raised on the next edge.
  a_r1_cause_raises: assert property (@(posedge clk) disable iff (srst)
    cause_i |=> held_o);

  // R7: no release while the window is still counting.
  a_r7_no_early_release: assert property (@(posedge clk) disable iff (srst)
    (held_o && !cause_i && !count_done) |=> held_o);

  // R2: a release happens only at the final count value.
  a_r2_release_at_end: assert property (@(posedge clk) disable iff (srst)
    $fell(held_o) |-> ($past(cnt_q) == CNT_LAST));

endmodule

// File: rtl/rst_pulse_seq.sv
module rst_pulse_seq #(
  parameter int unsigned HOLD_CYCLES = 40,
  parameter int unsigned DEB_CYCLES  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic srst,
  input  logic supply_ok_i,
  input  logic man_rst_n_i,
  input  logic wdog_bite_i,
  output logic rst_n_o,
  output logic rst_o
);

  logic supply_ok_s;
  logic man_n_s;
  logic man_n_deb;
  logic cause_supply;
  logic cause_manual;
  logic cause_any;
  logic held;

  rps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_supply (
    .clk (clk),
    .srst(srst),
    .d_i (supply_ok_i),
    .q_o (supply_ok_s)
  );

  rps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_manual (
    .clk (clk),
    .srst(srst),
    .d_i (man_rst_n_i),
    .q_o (man_n_s)
  );

  rps_debounce #(.DEB_CYCLES(DEB_CYCLES), .RST_VAL(1'b1)) i_deb_manual (
    .clk  (clk),
    .srst (srst),
    .in_i (man_n_s),
    .out_o(man_n_deb)
  );

  assign cause_supply = ~supply_ok_s;
  assign cause_manual = ~man_n_deb;
  assign cause_any    = cause_supply | cause_manual | wdog_bite_i;

  rps_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold (
    .clk    (clk),
    .srst   (srst),
    .cause_i(cause_any),
    .held_o (held)
  );

  assign rst_o   = held;
  assign rst_n_o = ~held;

  // R6: a watchdog strobe raises the reset pins on the next edge.
  a_r6_wdog_raises: assert property (@(posedge clk) disable iff (srst)
    wdog_bite_i |=> (rst_o && !rst_n_o));

  // R3: a debounced manual request keeps reset raised.
  a_r3_manual_holds: assert property (@(posedge clk) disable iff (srst)
    cause_manual |=> rst_o);

endmodule

// File: tb/test_rst_pulse_seq.sv
module test_rst_pulse_seq;

  localparam int HOLD = 40;
  localparam int DEB  = 8;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic supply_ok = 1'b1;
  logic man_n = 1'b1;
  logic wdog = 1'b0;
  logic rst_n_o;
  logic rst_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int    q_a[$];
  int    q_r[$];
  string q_n[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_pulse_seq #(.HOLD_CYCLES(HOLD), .DEB_CYCLES(DEB), .SYNC_STAGES(2)) i_rst_pulse_seq (
    .clk        (clk),
    .srst       (srst),
    .supply_ok_i(supply_ok),
    .man_rst_n_i(man_n),
    .wdog_bite_i(wdog),
    .rst_n_o    (rst_n_o),
    .rst_o      (rst_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_pulse(input string tag, input int a, input int r);
    q_n.push_back(tag);
    q_a.push_back(a);
    q_r.push_back(r);
  endtask

  // Monitor: measures each reset pulse and compares it with the queue head.
  bit prev = 1'b1;
  int rise_cyc = 0;
  always @(negedge clk) begin
    if (!srst) begin
      if (rst_o && !prev) begin
        rise_cyc = cyc;
        if (q_n.size() == 0) check("R5 unexpected reset rise", cyc, -1);
      end
      if (!rst_o && prev) begin
        check("R8 complement at release", int'(rst_n_o), 1);
        if (q_n.size() == 0) begin
          check("unexpected release", cyc, -1);
        end else begin
          string t;
          int ea;
          int er;
          t = q_n.pop_front();
          ea = q_a.pop_front();
          er = q_r.pop_front();
          check({t, " assert cycle"}, rise_cyc, ea);
          check({t, " release cycle"}, cyc, er);
        end
      end
      prev = rst_o;
    end
  end

  task automatic settle();
    repeat (HOLD + DEB + 12) @(negedge clk);
    check("queue drained", q_n.size(), 0);
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    // R9 and R8: reset state while srst is high
    check("R9 rst_o during srst", int'(rst_o), 1);
    check("R8 rst_n_o during srst", int'(rst_n_o), 0);
    p = cyc;
    expect_pulse("R9 power-on", 0, p + 2 + HOLD);
    srst = 1'b0;
    settle();

    // R1 R2: supply dropout of 5 cycles
    @(negedge clk); p = cyc;
    expect_pulse("R1/R2 supply", p + 3, p + 5 + 2 + HOLD);
    supply_ok = 1'b0;
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    settle();

    // R3 R4: manual low for 20 cycles
    @(negedge clk); p = cyc;
    expect_pulse("R3/R4 manual", p + 3 + DEB, p + 20 + 2 + DEB + HOLD);
    man_n = 1'b0;
    repeat (20) @(negedge clk);
    man_n = 1'b1;
    settle();

    // R5: manual glitch one cycle short of the debounce window
    @(negedge clk);
    man_n = 1'b0;
    repeat (DEB - 1) @(negedge clk);
    man_n = 1'b1;
    repeat (DEB + 6) @(negedge clk);
    check("R5 glitch ignored rst_o", int'(rst_o), 0);
    settle();

    // R6: single-cycle watchdog strobe
    @(negedge clk); p = cyc;
    expect_pulse("R6 wdog 1 cycle", p + 1, p + 1 + HOLD);
    wdog = 1'b1;
    @(negedge clk);
    wdog = 1'b0;
    settle();

    // R6: three-cycle watchdog strobe
    @(negedge clk); p = cyc;
    expect_pulse("R6 wdog 3 cycles", p + 1, p + 3 + HOLD);
    wdog = 1'b1;
    repeat (3) @(negedge clk);
    wdog = 1'b0;
    settle();

    // R7: supply dropout during the hold count restarts it
    @(negedge clk); p = cyc;
    expect_pulse("R7 restart", p + 1, p + 23 + 2 + HOLD);
    wdog = 1'b1;
    @(negedge clk);
    wdog = 1'b0;
    repeat (19) @(negedge clk);
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    settle();

    // R7 R3: overlapping supply and manual causes, manual clears last
    @(negedge clk); p = cyc;
    expect_pulse("R7 overlap", p + 3, p + 50 + 2 + DEB + HOLD);
    supply_ok = 1'b0;
    repeat (10) @(negedge clk);
    man_n = 1'b0;
    repeat (20) @(negedge clk);
    supply_ok = 1'b1;
    repeat (20) @(negedge clk);
    check("R3 held while manual low", int'(rst_o), 1);
    man_n = 1'b1;
    settle();

    check("R8 idle complement", int'(rst_n_o), 1);
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) check("watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule